// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a dynamic memory alive without any help from the access path. After reset it waits out the power-up settling time. It then runs a burst of initialisation refreshes and only then raises `ready`. The arbiter in front of the memory must hold back host accesses until that happens.

After start-up an interval timer adds one owed refresh to a small debt counter on every period. The block asks the arbiter for the shared strobe pins with `refReq`. Once `refGrant` is seen, it drives `rasN`/`casN` itself and marks this with `pinOwn`. It then runs refresh cycles with CAS leading RAS, back to back, until the debt is repaid. Because the memory keeps its own row counter in this refresh mode, no address is produced. The write-enable and address pins are left to the arbiter as don't-care, and the memory holds its data output at high impedance.

All timings are parameters counted in clock cycles. The defaults suit a 200 MHz clock: a 100 µs power-up wait and a 15.6 µs refresh interval. With these defaults, 512 refreshes fit inside 8 ms.

Top module: `rfsh_cbr_sched`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are 1, and `refReq`, `pinOwn` and `ready` are 0.
- R2: No refresh is owed during the first STARTUP_CYC clock edges after reset. `refReq` first reads 1 after edge STARTUP_CYC+1.
- R3: The first grant after start-up carries exactly INIT_REFRESHES back-to-back refreshes. `ready` rises in the cycle after the last of them drops RAS, and never before.
- R4: The block drives a strobe low only while `refGrant` is 1. `refReq` stays 1 for as long as `pinOwn` is 1.
- R5: After a grant, both strobes stay high for max(RP_CYC,RPC_CYC) cycles. CAS then falls, and RAS follows exactly CSR_CYC cycles later (CAS leads RAS).
- R6: RAS stays low for max(RAS_MIN_CYC,CHR_CYC) cycles, CAS stays low for that whole time, and the two strobes rise on the same edge.
- R7: Between two RAS low pulses, RAS stays high for at least max(RP_CYC,RPC_CYC) cycles.
- R8: After start-up, one refresh is owed every INTERVAL_CYC edges. With the grant given at once, consecutive single refreshes begin exactly INTERVAL_CYC cycles apart.
- R9: Refreshes owed while the grant is withheld build up in a debt that saturates at DEBT_MAX. All of the debt is repaid back to back under a single grant.
- R10: Once `ready` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Arbiter grants the strobe pins; must be held while `refReq` is 1 |
| refReq | output | 1 | Request for the strobe pins |
| pinOwn | output | 1 | Block is driving the strobes (arbiter mux select) |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| ready | output | 1 | Initialisation complete; host accesses may be granted |

## Verification
The hardest state to reach from the ports is the saturated debt followed by its repayment. It exists only when the arbiter has refused the pins for longer than DEBT_MAX refresh intervals. The stimulus withholds the grant for thirteen intervals, well past saturation, and then grants it. The bench then checks that the burst has at least DEBT_MAX refreshes and matches the reference model cycle for cycle. A model that counts owed refreshes from absolute cycle numbers also checks how the initialisation burst and the first ordinary tick line up.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOV
  } rfshState_t;

  typedef enum logic [1:0] {
    PH_PRE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV
  } phaseSel_t;

  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      refDone;
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int STARTUP_CYC    = 20000,
  parameter int INTERVAL_CYC   = 3120,
  parameter int INIT_REFRESHES = 8,
  parameter int DEBT_MAX       = 8,
  parameter int PRE_LEN        = 10,
  parameter int SETUP_LEN      = 2,
  parameter int STROBE_LEN     = 14,
  parameter int RECOV_LEN      = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  rfshStrobe_t strb,
  output logic        pending,
  output logic        phaseDone,
  output logic        ready
);

  localparam int TMAX = (STARTUP_CYC > INTERVAL_CYC) ? STARTUP_CYC : INTERVAL_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(DEBT_MAX + 1);
  localparam int IW   = $clog2(INIT_REFRESHES + 1);
  localparam int PM01 = (PRE_LEN > SETUP_LEN) ? PRE_LEN : SETUP_LEN;
  localparam int PM23 = (STROBE_LEN > RECOV_LEN) ? STROBE_LEN : RECOV_LEN;
  localparam int PMAX = (PM01 > PM23) ? PM01 : PM23;
  localparam int PW   = $clog2(PMAX + 1);

  logic [TW-1:0] timer;
  logic          pwrDone;
  logic          tick;
  logic          loadInit;
  logic [DW-1:0] debt;
  logic [DW-1:0] debtNext;
  logic [IW-1:0] initLeft;
  logic [PW-1:0] phaseCnt;
  logic [PW-1:0] phaseInit;

  // Power-up wait, then the refresh interval timer
  assign loadInit = !pwrDone && (timer == '0);
  assign tick     = pwrDone && (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer   <= TW'(STARTUP_CYC - 1);
      pwrDone <= 1'b0;
    end else if (timer == '0) begin
      timer   <= TW'(INTERVAL_CYC - 1);
      pwrDone <= 1'b1;
    end else begin
      timer <= timer - 1'b1;
    end
  end

  // Debt of owed refreshes, saturating
  always_comb begin
    debtNext = debt;
    if (loadInit) begin
      debtNext = DW'(INIT_REFRESHES);
    end else if (tick && !strb.refDone) begin
      debtNext = (debt == DW'(DEBT_MAX)) ? debt : debt + 1'b1;
    end else if (!tick && strb.refDone) begin
      debtNext = debt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) debt <= '0;
    else       debt <= debtNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initLeft <= '0;
    end else if (loadInit) begin
      initLeft <= IW'(INIT_REFRESHES);
    end else if (strb.refDone && initLeft != '0) begin
      initLeft <= initLeft - 1'b1;
    end
  end

  assign pending = (debt != '0);
  assign ready   = pwrDone && (initLeft == '0);

  // Phase length counter
  always_comb begin
    unique case (strb.phaseSel)
      PH_PRE:    phaseInit = PW'(PRE_LEN - 1);
      PH_SETUP:  phaseInit = PW'(SETUP_LEN - 1);
      PH_STROBE: phaseInit = PW'(STROBE_LEN - 1);
      default:   phaseInit = PW'(RECOV_LEN - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  phaseCnt <= '0;
    else if (strb.phaseLoad)    phaseCnt <= phaseInit;
    else if (phaseCnt != '0)    phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseDone = (phaseCnt == '0);

  AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    debt <= DW'(DEBT_MAX)) else $error("debt above limit"); // R9

  AST_QUIET_BEFORE_PWR: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDone |-> !pending && !ready) else $error("activity before power-up wait"); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready) else $error("ready dropped"); // R10

  AST_TICK_ADDS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.refDone && debt < DW'(DEBT_MAX)) |=> debt == $past(debt) + 1'b1)
    else $error("tick lost"); // R8

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int PRE_LEN    = 10,
  parameter int SETUP_LEN  = 2,
  parameter int STROBE_LEN = 14,
  parameter int RECOV_LEN  = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refGrant,
  input  logic        pending,
  input  logic        phaseDone,
  output rfshStrobe_t strb,
  output logic        refReq,
  output logic        pinOwn,
  output logic        rasN,
  output logic        casN
);

  localparam int CMAX = STROBE_LEN + PRE_LEN + SETUP_LEN;
  localparam int CW   = $clog2(CMAX + 1);

  rfshState_t state;
  rfshState_t stateNext;

  always_comb begin
    stateNext = state;
    strb      = '{phaseLoad: 1'b0, phaseSel: PH_PRE, refDone: 1'b0};
    unique case (state)
      ST_IDLE: if (pending) stateNext = ST_REQ;
      ST_REQ: if (refGrant) begin
        stateNext      = ST_PRE;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_PRE;
      end
      ST_PRE: if (phaseDone) begin
        stateNext      = ST_SETUP;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_SETUP;
      end
      ST_SETUP: if (phaseDone) begin
        stateNext      = ST_STROBE;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_STROBE;
      end
      ST_STROBE: if (phaseDone) begin
        stateNext      = ST_RECOV;
        strb.phaseLoad = 1'b1;
        strb.phaseSel  = PH_RECOV;
        strb.refDone   = 1'b1;
      end
      default: if (phaseDone) begin
        if (pending) begin
          stateNext      = ST_SETUP;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_SETUP;
        end else begin
          stateNext = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign refReq = (state != ST_IDLE);
  assign pinOwn = (state == ST_PRE) || (state == ST_SETUP) ||
                  (state == ST_STROBE) || (state == ST_RECOV);
  assign casN   = !((state == ST_SETUP) || (state == ST_STROBE));
  assign rasN   = !(state == ST_STROBE);

  // Run-length counters for the strobe width checks
  logic [CW-1:0] rasLowCnt;
  logic [CW-1:0] rasHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= '0;
    end else if (!rasN) begin
      rasHighCnt <= '0;
      if (rasLowCnt != CW'(CMAX)) rasLowCnt <= rasLowCnt + 1'b1;
    end else begin
      rasLowCnt <= '0;
      if (rasHighCnt != CW'(CMAX)) rasHighCnt <= rasHighCnt + 1'b1;
    end
  end

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN && !$past(casN)) else $error("RAS fell without CAS lead"); // R5

  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> rasLowCnt >= CW'(STROBE_LEN)) else $error("RAS pulse too short"); // R6

  AST_CAS_WITH_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN)) else $error("strobes released apart"); // R6

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> rasHighCnt >= CW'(PRE_LEN)) else $error("RAS precharge too short"); // R7

  AST_PINS_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> refGrant) else $error("strobe driven without grant"); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pinOwn |-> refReq) else $error("request dropped while owning pins"); // R4

endmodule

// File: rtl/rfsh_cbr_sched.sv
module rfsh_cbr_sched
  import rfsh_pkg::*;
#(
  parameter int STARTUP_CYC    = 20000,
  parameter int INTERVAL_CYC   = 3120,
  parameter int INIT_REFRESHES = 8,
  parameter int DEBT_MAX       = 8,
  parameter int RP_CYC         = 10,
  parameter int RPC_CYC        = 2,
  parameter int CSR_CYC        = 2,
  parameter int CHR_CYC        = 6,
  parameter int RAS_MIN_CYC    = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic pinOwn,
  output logic rasN,
  output logic casN,
  output logic ready
);

  localparam int PRE_LEN    = (RP_CYC > RPC_CYC) ? RP_CYC : RPC_CYC;
  localparam int SETUP_LEN  = CSR_CYC;
  localparam int STROBE_LEN = (RAS_MIN_CYC > CHR_CYC) ? RAS_MIN_CYC : CHR_CYC;
  localparam int RECOV_LEN  = PRE_LEN;

  rfshStrobe_t strb;
  logic        pending;
  logic        phaseDone;

  rfsh_ctrl #(
    .PRE_LEN   (PRE_LEN),
    .SETUP_LEN (SETUP_LEN),
    .STROBE_LEN(STROBE_LEN),
    .RECOV_LEN (RECOV_LEN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .pending  (pending),
    .phaseDone(phaseDone),
    .strb     (strb),
    .refReq   (refReq),
    .pinOwn   (pinOwn),
    .rasN     (rasN),
    .casN     (casN)
  );

  rfsh_datapath #(
    .STARTUP_CYC   (STARTUP_CYC),
    .INTERVAL_CYC  (INTERVAL_CYC),
    .INIT_REFRESHES(INIT_REFRESHES),
    .DEBT_MAX      (DEBT_MAX),
    .PRE_LEN       (PRE_LEN),
    .SETUP_LEN     (SETUP_LEN),
    .STROBE_LEN    (STROBE_LEN),
    .RECOV_LEN     (RECOV_LEN)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pending  (pending),
    .phaseDone(phaseDone),
    .ready    (ready)
  );

endmodule

// File: tb/tb_rfsh_cbr_sched.sv
`timescale 1ns/1ps
module tb_rfsh_cbr_sched;

  localparam int ST    = 50;
  localparam int INIT  = 8;
  localparam int INTV  = 400;
  localparam int DMAX  = 10;
  localparam int LPRE  = 10;
  localparam int LSET  = 2;
  localparam int LSTR  = 14;
  localparam int LREC  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic allow = 1'b1;
  logic refReq, pinOwn, rasN, casN, ready;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rfsh_cbr_sched #(
    .STARTUP_CYC(ST), .INTERVAL_CYC(INTV), .INIT_REFRESHES(INIT), .DEBT_MAX(DMAX),
    .RP_CYC(10), .RPC_CYC(2), .CSR_CYC(2), .CHR_CYC(6), .RAS_MIN_CYC(14)
  ) dut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .pinOwn(pinOwn), .rasN(rasN), .casN(casN), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle", req, act, exp);
    end
  endtask

  // Arbiter: grants a pending request when allowed, holds it while requested
  always @(negedge clk) refGrant <= refReq && (allow || refGrant);

  // Behavioural reference model: 0 idle,1 req,2 pre,3 setup,4 strobe,5 recov
  int mCyc = 0, mSt = 0, mLeft = 0, mDebt = 0, mInit = 0, mDoneCnt = 0;
  bit mPwr = 0;
  always @(posedge clk) begin
    if (rstN) begin
      bit tickNow, doneNow;
      int nDebt;
      mCyc++;
      tickNow = mPwr && (mCyc > ST) && ((mCyc - ST) % INTV == 0);
      doneNow = (mSt == 4) && (mLeft == 1);
      case (mSt)
        0: if (mDebt > 0) mSt = 1;
        1: if (refGrant) begin mSt = 2; mLeft = LPRE; end
        2: if (mLeft == 1) begin mSt = 3; mLeft = LSET; end else mLeft--;
        3: if (mLeft == 1) begin mSt = 4; mLeft = LSTR; end else mLeft--;
        4: if (mLeft == 1) begin mSt = 5; mLeft = LREC; end else mLeft--;
        default: if (mLeft == 1) begin
          if (mDebt > 0) begin mSt = 3; mLeft = LSET; end else mSt = 0;
        end else mLeft--;
      endcase
      if (mCyc == ST) begin
        nDebt = INIT; mInit = INIT; mPwr = 1;
      end else begin
        nDebt = mDebt + (tickNow ? 1 : 0) - (doneNow ? 1 : 0);
        if (nDebt > DMAX) nDebt = DMAX;
        if (doneNow && mInit > 0) mInit--;
      end
      if (doneNow) mDoneCnt++;
      mDebt = nDebt;
    end
  end

  // Port observation away from the active edge
  bit pRas = 1, pCas = 1, pOwn = 0, pReq = 0, pReady = 0, seenReq = 0, afterHold = 0;
  int casLowRun = 0, rasLowRun = 0, rasHighRun = 0, burstCnt = 0, burstIdx = 0;
  int lastFall = -1, lastBurstLen = 0;

  always @(negedge clk) begin
    if (rstN) begin
      // cycle-by-cycle comparison against the model
      check(rasN == (mSt != 4), "R6 rasN", rasN, mSt != 4);
      check(casN == !(mSt == 3 || mSt == 4), "R5 casN", casN, !(mSt == 3 || mSt == 4));
      check(refReq == (mSt != 0), "R9 refReq", refReq, mSt != 0);
      check(pinOwn == (mSt >= 2), "R4 pinOwn", pinOwn, mSt >= 2);
      check(ready == (mPwr && mInit == 0), "R3 ready", ready, mPwr && mInit == 0);
      if (!rasN || !casN) check(refGrant, "R4 strobe without grant", refGrant, 1);
      if (pReady) check(ready, "R10 ready sticky", ready, 1);

      if (refReq && !seenReq) begin
        seenReq = 1;
        check(mCyc == ST + 1, "R2 first request cycle", mCyc, ST + 1);
      end
      if (ready && !pReady) check(burstCnt == INIT, "R3 refreshes before ready", burstCnt, INIT);

      if (pinOwn && !pOwn) burstCnt = 0;
      if (pRas && !rasN) begin
        check(casLowRun == LSET, "R5 CAS lead", casLowRun, LSET);
        check(rasHighRun >= LPRE, "R7 RAS precharge", rasHighRun, LPRE);
        burstCnt++;
      end
      if (!pRas && rasN) begin
        check(rasLowRun == LSTR, "R6 RAS width", rasLowRun, LSTR);
        check(casN, "R6 CAS released with RAS", casN, 1);
      end
      if (!pinOwn && pOwn) begin
        burstIdx++;
        if (burstIdx == 1) check(burstCnt == INIT, "R3 init burst length", burstCnt, INIT);
        if (afterHold) begin
          check(burstCnt >= DMAX && burstCnt <= DMAX + 1, "R9 catch-up burst", burstCnt, DMAX);
          afterHold = 0;
        end
        if (burstCnt == 1 && lastBurstLen == 1 && burstIdx > 2 && allow)
          check(mCyc - lastFall == INTV + LPRE + LSET + LSTR + LREC + 1 - (LPRE + LSET + LSTR + LREC + 1),
                "R8 interval", mCyc - lastFall, INTV);
        lastFall = mCyc;
        lastBurstLen = burstCnt;
      end

      casLowRun  = casN ? 0 : casLowRun + 1;
      rasLowRun  = rasN ? 0 : rasLowRun + 1;
      rasHighRun = rasN ? rasHighRun + 1 : 0;
      pRas = rasN; pCas = casN; pOwn = pinOwn; pReq = refReq; pReady = ready;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(rasN && casN, "R1 strobes in reset", {rasN, casN}, 3);
    check(!refReq && !pinOwn, "R1 request idle in reset", {refReq, pinOwn}, 0);
    check(!ready, "R1 ready in reset", ready, 0);
    rstN = 1'b1;
    repeat (ST + 4 * INTV) @(negedge clk);
    allow = 1'b0;
    repeat (13 * INTV) @(negedge clk);
    check(refReq && !pinOwn, "R9 request waits for grant", {refReq, pinOwn}, 2);
    afterHold = 1;
    allow = 1'b1;
    repeat (4 * INTV) @(negedge clk);
    check(mDoneCnt > INIT + DMAX, "R8 refreshes issued", mDoneCnt, INIT + DMAX);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule